// File: doc/BRIEF.md
# Real-Time-Clock Register Transaction Tracker

This block listens to the byte-level event stream produced by an I2C front end and follows the register transactions aimed at one real-time-clock target. Each event arrives as a one-cycle strobe. The strobe carries a kind code and a data byte. The block reconstructs the register pointer that the bus master sets up, and advances that pointer after every data byte. It also keeps a shadow copy of the control and time/date registers as they pass on the bus.

When a transaction closes with STOP, the block emits a one-cycle completion pulse. The pulse says whether the transaction was a write or a read, and carries the seconds, minutes, hours, day, weekday, month and year converted from BCD to binary. It also carries the voltage-low and century flags, the five control bits, and one valid bit per register. Each valid bit tells whether that register was moved in the transaction that just ended.

A read is recognised from its bus order. The pointer is first loaded by a write, then a repeated START follows, then an address-read. Traffic addressed to other devices sends the tracker back to idle.

Top module: `rtc_txn_tracker`

## Requirements
- R1: Event kind codes on `ev_kind` are 0 START, 1 repeated START, 2 address-write, 3 address-read, 4 data-write, 5 data-read, 6 STOP and 7 none. While idle, every event except START is ignored.
- R2: After START, an address-write event with byte 0xA2 makes the tracker wait for a pointer. The next data-write byte then loads the pointer with its low 4 bits.
- R3: Once the pointer is loaded, each data-write byte is stored to the register the pointer selects, and the pointer then increments by one, wrapping from 0xF to 0x0.
- R4: A repeated START after the pointer is loaded, followed by an address-read event with byte 0xA3, enters the read phase. In that phase each data-read byte is captured at the pointer, which then increments.
- R5: A STOP in the write or read data phase returns the tracker to idle. In the next cycle `done` is high for exactly one cycle, with `done_rd` at 1 for a read and 0 for a write.
- R6: Register 2 gives seconds from bits 6:0 and `volt_low` from bit 7. Register 3 gives minutes from bits 6:0. Registers 4 and 5 give hour and day from bits 5:0. Register 6 gives the weekday from bits 2:0. Register 7 gives the month from bits 4:0 and `century` from bit 7. Register 8 gives the year from bits 7:0. Each BCD field is reported as low nibble plus ten times high nibble.
- R7: Register 1 gives `ctrl_bits` from its bits 4:0: bit 4 is timer repeat, bit 3 the alarm flag, bit 2 the timer flag, bit 1 the alarm interrupt enable and bit 0 the timer interrupt enable.
- R8: `fld_valid` bit k (k=0..7) reports whether register k+1 was transferred in the finished transaction. All bits clear at each START taken from idle, and registers 0 and 9 to 15 affect no output.
- R9: An address-write byte other than 0xA2, or an address-read byte other than 0xA3, returns the tracker to idle with no completion.
- R10: Out-of-order events are ignored and the tracker keeps its state. Examples are a data event before the pointer is loaded, a repeated START before the pointer is loaded, and a START in mid-transaction.
- R11: Synchronous reset clears `done`, every reported field and `fld_valid`, and puts the tracker in idle. The reported fields hold their values between completion pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event strobe |
| ev_kind | input | 3 | Event kind code |
| ev_byte | input | 8 | Byte carried by the event |
| done | output | 1 | One-cycle transaction completion pulse |
| done_rd | output | 1 | 1 = finished read, 0 = finished write |
| sec_bin | output | 7 | Seconds, binary |
| min_bin | output | 7 | Minutes, binary |
| hour_bin | output | 6 | Hours, binary |
| day_bin | output | 6 | Day of month, binary |
| wday | output | 3 | Weekday |
| mon_bin | output | 5 | Month, binary |
| year_bin | output | 8 | Year, binary |
| volt_low | output | 1 | Voltage-low flag |
| century | output | 1 | Century flag |
| ctrl_bits | output | 5 | Control register bits 4:0 |
| fld_valid | output | 8 | Per-register transferred flags, registers 1 to 8 |

## Verification
The bound checker watches the sequencing rules on every cycle:
- the idle state ignores everything except START;
- a mismatched write address drops back to idle;
- the pointer steps by one after each stored byte, including the wrap;
- the read phase is entered only from an address-read carrying 0xA3;
- the valid flags are cleared at a new transaction;
- `done` appears only after a STOP and never lasts two cycles.

The field layout, the BCD conversion and the valid masks depend on the byte values in whole transactions, so only the bench scenarios can show them. Those scenarios are a full write, a partial read, pointer wrap, the voltage-low and century bits, and the foreign-address and out-of-order streams.

// File: rtl/rtcx_pkg.sv
package rtcx_pkg;

  typedef enum logic [2:0] {
    EV_START  = 3'd0,
    EV_RSTART = 3'd1,
    EV_ADDR_W = 3'd2,
    EV_ADDR_R = 3'd3,
    EV_DATA_W = 3'd4,
    EV_DATA_R = 3'd5,
    EV_STOP   = 3'd6,
    EV_NONE   = 3'd7
  } ev_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WAIT_AW  = 3'd1,
    ST_WAIT_PTR = 3'd2,
    ST_WR_DATA  = 3'd3,
    ST_WAIT_AR  = 3'd4,
    ST_RD_DATA  = 3'd5
  } trk_state_e;

  // shadowed register window
  localparam int SHADOW_FIRST = 1;
  localparam int SHADOW_LAST  = 8;

endpackage

// File: rtl/rtcx_bcd2bin.sv
module rtcx_bcd2bin #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  bcd,
  output logic [OUT_W-1:0] bin
);
  logic [OUT_W-1:0] lo_ext;
  logic [OUT_W-1:0] hi_ext;

  assign lo_ext = OUT_W'(bcd[3:0]);
  assign hi_ext = OUT_W'(bcd[IN_W-1:4]);
  // hi*10 = hi*8 + hi*2
  assign bin    = lo_ext + (hi_ext << 3) + (hi_ext << 1);
endmodule

// File: rtl/rtcx_seq.sv
module rtcx_seq
  import rtcx_pkg::*;
#(
  parameter int          PTR_W   = 4,
  parameter logic [7:0]  ADDR_WR = 8'hA2,
  parameter logic [7:0]  ADDR_RD = 8'hA3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_valid,
  input  logic [2:0]       ev_kind,
  input  logic [7:0]       ev_byte,
  output trk_state_e       st,
  output logic [PTR_W-1:0] ptr,
  output logic             store_en,
  output logic             txn_start,
  output logic             fin,
  output logic             fin_rd
);
  ev_kind_e         kind;
  trk_state_e       st_n;
  logic [PTR_W-1:0] ptr_n;

  assign kind = ev_kind_e'(ev_kind);

  always_comb begin
    st_n  = st;
    ptr_n = ptr;
    if (ev_valid) begin
      case (st)
        ST_IDLE:
          if (kind == EV_START) st_n = ST_WAIT_AW;
        ST_WAIT_AW:
          if (kind == EV_ADDR_W)
            st_n = (ev_byte == ADDR_WR) ? ST_WAIT_PTR : ST_IDLE;
        ST_WAIT_PTR:
          if (kind == EV_DATA_W) begin
            ptr_n = ev_byte[PTR_W-1:0];
            st_n  = ST_WR_DATA;
          end
        ST_WR_DATA:
          case (kind)
            EV_DATA_W: ptr_n = ptr + 1'b1;
            EV_RSTART: st_n  = ST_WAIT_AR;
            EV_STOP:   st_n  = ST_IDLE;
            default:   ;
          endcase
        ST_WAIT_AR:
          if (kind == EV_ADDR_R)
            st_n = (ev_byte == ADDR_RD) ? ST_RD_DATA : ST_IDLE;
        ST_RD_DATA:
          case (kind)
            EV_DATA_R: ptr_n = ptr + 1'b1;
            EV_STOP:   st_n  = ST_IDLE;
            default:   ;
          endcase
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      ptr <= '0;
    end else begin
      st  <= st_n;
      ptr <= ptr_n;
    end
  end

  assign store_en  = ev_valid &&
                     ((st == ST_WR_DATA && kind == EV_DATA_W) ||
                      (st == ST_RD_DATA && kind == EV_DATA_R));
  assign txn_start = ev_valid && st == ST_IDLE && kind == EV_START;
  assign fin       = ev_valid && kind == EV_STOP &&
                     (st == ST_WR_DATA || st == ST_RD_DATA);
  assign fin_rd    = (st == ST_RD_DATA);
endmodule

// File: rtl/rtcx_shadow.sv
module rtcx_shadow #(
  parameter int PTR_W = 4,
  parameter int FIRST = 1,
  parameter int LAST  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  wr_en,
  input  logic [PTR_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  output logic [LAST-FIRST:0][7:0] regs,
  output logic [LAST-FIRST:0]   valid
);
  localparam int NREG = LAST - FIRST + 1;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [PTR_W-1:0] IDX = PTR_W'(g + FIRST);
    logic hit;
    assign hit = wr_en && (wr_idx == IDX);

    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (hit) begin
        regs[g] <= wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        valid[g] <= 1'b0;
      end else if (hit) begin
        valid[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_txn_tracker.sv
module rtc_txn_tracker
  import rtcx_pkg::*;
#(
  parameter int         PTR_W   = 4,
  parameter logic [7:0] ADDR_WR = 8'hA2,
  parameter logic [7:0] ADDR_RD = 8'hA3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_valid,
  input  logic [2:0] ev_kind,
  input  logic [7:0] ev_byte,
  output logic       done,
  output logic       done_rd,
  output logic [6:0] sec_bin,
  output logic [6:0] min_bin,
  output logic [5:0] hour_bin,
  output logic [5:0] day_bin,
  output logic [2:0] wday,
  output logic [4:0] mon_bin,
  output logic [7:0] year_bin,
  output logic       volt_low,
  output logic       century,
  output logic [4:0] ctrl_bits,
  output logic [7:0] fld_valid
);
  localparam int NREG = SHADOW_LAST - SHADOW_FIRST + 1;
  // slot numbers inside the shadow window
  localparam int S_CTRL = 1 - SHADOW_FIRST;
  localparam int S_SEC  = 2 - SHADOW_FIRST;
  localparam int S_MIN  = 3 - SHADOW_FIRST;
  localparam int S_HOUR = 4 - SHADOW_FIRST;
  localparam int S_DAY  = 5 - SHADOW_FIRST;
  localparam int S_WDAY = 6 - SHADOW_FIRST;
  localparam int S_MON  = 7 - SHADOW_FIRST;
  localparam int S_YEAR = 8 - SHADOW_FIRST;

  trk_state_e           st;
  logic [PTR_W-1:0]     ptr;
  logic                 store_en, txn_start, fin, fin_rd;
  logic [NREG-1:0][7:0] shd;
  logic [NREG-1:0]      shd_valid;
  logic [6:0]           sec_c, min_c;
  logic [5:0]           hour_c, day_c;
  logic [4:0]           mon_c;
  logic [7:0]           year_c;

  rtcx_seq #(.PTR_W(PTR_W), .ADDR_WR(ADDR_WR), .ADDR_RD(ADDR_RD)) u_seq (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_byte(ev_byte), .st(st), .ptr(ptr), .store_en(store_en),
    .txn_start(txn_start), .fin(fin), .fin_rd(fin_rd)
  );

  rtcx_shadow #(.PTR_W(PTR_W), .FIRST(SHADOW_FIRST), .LAST(SHADOW_LAST)) u_shadow (
    .clk(clk), .rst(rst), .clr(txn_start), .wr_en(store_en),
    .wr_idx(ptr), .wr_data(ev_byte), .regs(shd), .valid(shd_valid)
  );

  rtcx_bcd2bin #(.IN_W(7), .OUT_W(7)) u_sec  (.bcd(shd[S_SEC][6:0]),  .bin(sec_c));
  rtcx_bcd2bin #(.IN_W(7), .OUT_W(7)) u_min  (.bcd(shd[S_MIN][6:0]),  .bin(min_c));
  rtcx_bcd2bin #(.IN_W(6), .OUT_W(6)) u_hour (.bcd(shd[S_HOUR][5:0]), .bin(hour_c));
  rtcx_bcd2bin #(.IN_W(6), .OUT_W(6)) u_day  (.bcd(shd[S_DAY][5:0]),  .bin(day_c));
  rtcx_bcd2bin #(.IN_W(5), .OUT_W(5)) u_mon  (.bcd(shd[S_MON][4:0]),  .bin(mon_c));
  rtcx_bcd2bin #(.IN_W(8), .OUT_W(8)) u_year (.bcd(shd[S_YEAR]),      .bin(year_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      done_rd   <= 1'b0;
      sec_bin   <= '0;
      min_bin   <= '0;
      hour_bin  <= '0;
      day_bin   <= '0;
      wday      <= '0;
      mon_bin   <= '0;
      year_bin  <= '0;
      volt_low  <= 1'b0;
      century   <= 1'b0;
      ctrl_bits <= '0;
      fld_valid <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        done_rd   <= fin_rd;
        sec_bin   <= sec_c;
        min_bin   <= min_c;
        hour_bin  <= hour_c;
        day_bin   <= day_c;
        wday      <= shd[S_WDAY][2:0];
        mon_bin   <= mon_c;
        year_bin  <= year_c;
        volt_low  <= shd[S_SEC][7];
        century   <= shd[S_MON][7];
        ctrl_bits <= shd[S_CTRL][4:0];
        fld_valid <= 8'(shd_valid);
      end
    end
  end
endmodule

// File: rtl/rtcx_chk.sv
module rtcx_chk
  import rtcx_pkg::*;
#(
  parameter int         PTR_W   = 4,
  parameter logic [7:0] ADDR_WR = 8'hA2,
  parameter logic [7:0] ADDR_RD = 8'hA3,
  parameter int         NREG    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ev_valid,
  input logic [2:0]       ev_kind,
  input logic [7:0]       ev_byte,
  input logic             done,
  input trk_state_e       st,
  input logic [PTR_W-1:0] ptr,
  input logic [NREG-1:0]  shd_valid
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !(ev_valid && ev_kind == 3'd0)) |=> st == ST_IDLE); // R1

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WR_DATA && ev_valid && ev_kind == 3'd4)
      |=> ptr == PTR_W'($past(ptr) + 1'b1)); // R3

  AST_RD_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RD_DATA && $past(st) != ST_RD_DATA)
      |-> ($past(st) == ST_WAIT_AR && $past(ev_valid) &&
           $past(ev_kind) == 3'd3 && $past(ev_byte) == ADDR_RD)); // R4

  AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(ev_valid) && $past(ev_kind) == 3'd6)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5

  AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && ev_valid && ev_kind == 3'd0) |=> shd_valid == '0); // R8

  AST_FOREIGN_ADDR: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT_AW && ev_valid && ev_kind == 3'd2 && ev_byte != ADDR_WR)
      |=> st == ST_IDLE); // R9
endmodule

bind rtc_txn_tracker rtcx_chk #(
  .PTR_W(PTR_W), .ADDR_WR(ADDR_WR), .ADDR_RD(ADDR_RD), .NREG(NREG)
) u_chk (
  .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
  .ev_byte(ev_byte), .done(done), .st(st), .ptr(ptr), .shd_valid(shd_valid)
);

// File: tb/sim_rtc_txn_tracker.sv
`timescale 1ns/1ps
module sim_rtc_txn_tracker;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ev_valid = 1'b0;
  logic [2:0] ev_kind = 3'd7;
  logic [7:0] ev_byte = 8'h00;
  logic       done, done_rd, volt_low, century;
  logic [6:0] sec_bin, min_bin;
  logic [5:0] hour_bin, day_bin;
  logic [2:0] wday;
  logic [4:0] mon_bin, ctrl_bits;
  logic [7:0] year_bin, fld_valid;

  int nchk = 0;
  int nerr = 0;

  localparam logic [2:0] K_ST = 3'd0, K_RS = 3'd1, K_AW = 3'd2, K_AR = 3'd3,
                         K_DW = 3'd4, K_DR = 3'd5, K_SP = 3'd6;

  // {kind, byte, expected done, expected done_rd}
  localparam int NVEC = 12;
  localparam logic [12:0] VEC [NVEC] = '{
    {K_DW, 8'h11, 1'b0, 1'b0},   // idle ignores data (R1)
    {K_ST, 8'h00, 1'b0, 1'b0},
    {K_AW, 8'hA2, 1'b0, 1'b0},
    {K_DW, 8'h02, 1'b0, 1'b0},   // pointer = 2 (R2)
    {K_DW, 8'h45, 1'b0, 1'b0},
    {K_DW, 8'h59, 1'b0, 1'b0},
    {K_DW, 8'h23, 1'b0, 1'b0},
    {K_DW, 8'h31, 1'b0, 1'b0},
    {K_DW, 8'h05, 1'b0, 1'b0},
    {K_DW, 8'h92, 1'b0, 1'b0},
    {K_DW, 8'h99, 1'b0, 1'b0},
    {K_SP, 8'h00, 1'b1, 1'b0}    // write done (R5)
  };

  rtc_txn_tracker u0 (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_byte(ev_byte), .done(done), .done_rd(done_rd), .sec_bin(sec_bin),
    .min_bin(min_bin), .hour_bin(hour_bin), .day_bin(day_bin), .wday(wday),
    .mon_bin(mon_bin), .year_bin(year_bin), .volt_low(volt_low),
    .century(century), .ctrl_bits(ctrl_bits), .fld_valid(fld_valid)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one event strobe; returns after the edge that consumed it
  task automatic ev(input logic [2:0] k, input logic [7:0] b);
    @(negedge clk);
    ev_valid = 1'b1;
    ev_kind  = k;
    ev_byte  = b;
    @(negedge clk);
    ev_valid = 1'b0;
    ev_kind  = 3'd7;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 done", done, 0);
    chk("R11 fld_valid", fld_valid, 0);
    chk("R11 sec", sec_bin, 0);
    rst = 1'b0;

    // table walk: full write of registers 2..8
    for (int i = 0; i < NVEC; i++) begin
      ev(VEC[i][12:10], VEC[i][9:2]);
      chk("R5 done vec", done, VEC[i][1]);
      if (VEC[i][1]) chk("R5 done_rd vec", done_rd, VEC[i][0]);
    end
    chk("R6 sec", sec_bin, 45);
    chk("R6 min", min_bin, 59);
    chk("R6 hour", hour_bin, 23);
    chk("R6 day", day_bin, 31);
    chk("R6 wday", wday, 5);
    chk("R6 month", mon_bin, 12);
    chk("R6 century", century, 1);
    chk("R6 year", year_bin, 99);
    chk("R6 volt_low", volt_low, 0);
    chk("R8 valid after write", fld_valid, 8'hFE);
    @(negedge clk);
    chk("R5 pulse one cycle", done, 0);
    chk("R11 hold", year_bin, 99);

    // R4 read of month and year
    ev(K_ST, 8'h00); ev(K_AW, 8'hA2); ev(K_DW, 8'h07);
    ev(K_RS, 8'h00); ev(K_AR, 8'hA3);
    ev(K_DR, 8'h15); ev(K_DR, 8'h07);
    ev(K_SP, 8'h00);
    chk("R4 done", done, 1);
    chk("R4 done_rd", done_rd, 1);
    chk("R4 month", mon_bin, 15);
    chk("R4 century", century, 0);
    chk("R4 year", year_bin, 7);
    chk("R8 valid after read", fld_valid, 8'hC0);

    // R9 foreign write address
    ev(K_ST, 8'h00); ev(K_AW, 8'hD0);
    ev(K_DW, 8'h03); ev(K_DW, 8'h11); ev(K_SP, 8'h00);
    chk("R9 no done foreign aw", done, 0);

    // R9 foreign read address
    ev(K_ST, 8'h00); ev(K_AW, 8'hA2); ev(K_DW, 8'h02);
    ev(K_RS, 8'h00); ev(K_AR, 8'hA5);
    ev(K_DR, 8'h11); ev(K_SP, 8'h00);
    chk("R9 no done foreign ar", done, 0);

    // R1 idle ignores STOP and data-read
    ev(K_DR, 8'h22); ev(K_SP, 8'h00);
    chk("R1 idle stop ignored", done, 0);

    // R10 out-of-order events
    ev(K_ST, 8'h00); ev(K_AW, 8'hA2);
    ev(K_DR, 8'h55); ev(K_RS, 8'h00);
    ev(K_DW, 8'h02); ev(K_DW, 8'h33);
    ev(K_ST, 8'h00); ev(K_SP, 8'h00);
    chk("R10 done", done, 1);
    chk("R10 done_rd", done_rd, 0);
    chk("R10 sec", sec_bin, 33);
    chk("R10 valid", fld_valid, 8'h02);

    // R3 pointer wrap, R7 control bits, R8 regs 15/0 inert
    ev(K_ST, 8'h00); ev(K_AW, 8'hA2); ev(K_DW, 8'h0F);
    ev(K_DW, 8'hAA); ev(K_DW, 8'h0A); ev(K_DW, 8'h1B);
    ev(K_SP, 8'h00);
    chk("R3 wrap valid", fld_valid, 8'h01);
    chk("R7 ctrl", ctrl_bits, 5'h1B);
    chk("R8 sec untouched", sec_bin, 33);

    // R6 voltage-low bit
    ev(K_ST, 8'h00); ev(K_AW, 8'hA2); ev(K_DW, 8'h02);
    ev(K_DW, 8'h87); ev(K_SP, 8'h00);
    chk("R6 vl flag", volt_low, 1);
    chk("R6 vl sec", sec_bin, 7);

    summary();
    $finish;
  end
endmodule